// File: doc/BRIEF.md
# Segmented Converter Input Decoder and Register

This block is the digital front end of a 12-bit segmented current-steering converter. On every rising edge of its latch-enable clock it takes a 12-bit code and splits it three ways. The top four bits become a 15-line thermometer group of equal-weight unit switches. The next two bits stay binary-weighted and drive two separate switches. The bottom six bits go undecoded to the six ladder-section switches. Decoding comes before the storage stage, and all switch controls sit in one edge-triggered master/slave register. Every switch therefore changes at the same instant, and the outputs stay still while the input moves between edges.

For checking, the block also gives an integer model of the two complementary output levels. Both are rebuilt from the registered switch controls. The true level is the stored code in LSB units. The complementary level is full scale minus one LSB minus the true level. In the port table, bit 1 of the code (its MSB) is `code_in[11]` and bit 12 (its LSB) is `code_in[0]`.

Top module: `seg_dac_front`

## Requirements
- R1: `seg_unit` is a thermometer code of `code_in[11:8]`. A value k in that field drives exactly `seg_unit[k-1:0]` high and every other line low, so k = 0 gives no lines.
- R2: `seg_bin[1]` follows `code_in[7]` (weight 128 LSB) and `seg_bin[0]` follows `code_in[6]` (weight 64 LSB). These two bits are not thermometer decoded.
- R3: `seg_lad[5:0]` follows `code_in[5:0]` bit for bit, with no decoding.
- R4: The controls take the code that is present at a rising edge of `le` and show it after that edge. All control groups update on that same edge.
- R5: A change of `code_in` while `le` is high, or at any other time between two rising edges, has no effect on any output until the next rising edge.
- R6: `lvl_true` equals the stored code. `lvl_comp` equals 4095 minus `lvl_true`, so the two always sum to 4095.
- R7: If `rst_n` is low at a rising edge of `le`, the next state is the zero code: no unit lines, binary bits or ladder bits are set, `lvl_true` is 0 and `lvl_comp` is 4095.
- R8: The weighted sum of the stored controls equals the stored code. Each unit line counts 256, the binary bits count 128 and 64, and the ladder bits count 32 down to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| le | input | 1 | Latch-enable clock; capture on the rising edge |
| rst_n | input | 1 | Active-low reset, synchronous to `le` |
| code_in | input | 12 | Input code; bit 11 is the MSB |
| seg_unit | output | 15 | Registered thermometer unit-switch lines |
| seg_bin | output | 2 | Registered binary-weighted switch controls |
| seg_lad | output | 6 | Registered ladder-section switch controls |
| lvl_true | output | 12 | Model of the true output level in LSB units |
| lvl_comp | output | 12 | Model of the complementary output level in LSB units |

## Verification
The bench sweeps all 4096 codes in rising order. For each code it checks the unit-line shape and count, the binary and ladder bits, the weighted reconstruction and the level pair. Together these checks separate the three segment boundaries and catch any swap of bit weight between the groups. Each capture is followed by the bitwise inverse of the code, driven while `le` is high. A transparent register, or one that samples on the wrong edge, would then show the inverted code instead of the stored one. A reset applied partway through the sweep, with a nonzero code on the input, shows that reset wins over data.

// File: rtl/seg_dac_front.sv
module seg_dac_front #(
  parameter int TH_W = 4,
  parameter int BN_W = 2,
  parameter int LD_W = 6,
  localparam int W    = TH_W + BN_W + LD_W,
  localparam int TH_N = (1 << TH_W) - 1
) (
  input  logic            le,
  input  logic            rst_n,
  input  logic [W-1:0]    code_in,
  output logic [TH_N-1:0] seg_unit,
  output logic [BN_W-1:0] seg_bin,
  output logic [LD_W-1:0] seg_lad,
  output logic [W-1:0]    lvl_true,
  output logic [W-1:0]    lvl_comp
);

  localparam logic [W-1:0] FULL = {W{1'b1}};

  logic [TH_W-1:0] top_f;
  logic [TH_N-1:0] unit_d;

  assign top_f = code_in[W-1 -: TH_W];

  for (genvar i = 0; i < TH_N; i++) begin : g_therm
    assign unit_d[i] = (top_f > TH_W'(i));
  end

  always_ff @(posedge le) begin
    if (!rst_n) begin
      seg_unit <= '0;
      seg_bin  <= '0;
      seg_lad  <= '0;
    end else begin
      seg_unit <= unit_d;
      seg_bin  <= code_in[LD_W +: BN_W];
      seg_lad  <= code_in[LD_W-1:0];
    end
  end

  logic [W-1:0] unit_cnt;

  always_comb begin
    unit_cnt = '0;
    for (int i = 0; i < TH_N; i++) unit_cnt = unit_cnt + W'(seg_unit[i]);
  end

  assign lvl_true = (unit_cnt << (BN_W + LD_W)) + W'({seg_bin, seg_lad});
  assign lvl_comp = FULL - lvl_true;

endmodule

// File: rtl/seg_dac_front_chk.sv
module seg_dac_front_chk (
  input logic        le,
  input logic        rst_n,
  input logic [11:0] code_in,
  input logic [14:0] seg_unit,
  input logic [1:0]  seg_bin,
  input logic [5:0]  seg_lad,
  input logic [11:0] lvl_true,
  input logic [11:0] lvl_comp
);

  p_therm_shape_r1: assert property (@(posedge le) disable iff (!rst_n)
    ((seg_unit + 15'd1) & seg_unit) == 15'd0);

  p_bin_follow_r2: assert property (@(posedge le) disable iff (!rst_n)
    rst_n |=> seg_bin == $past(code_in[7:6]));

  p_lad_follow_r3: assert property (@(posedge le) disable iff (!rst_n)
    rst_n |=> seg_lad == $past(code_in[5:0]));

  p_capture_r4: assert property (@(posedge le) disable iff (!rst_n)
    rst_n |=> lvl_true == $past(code_in));

  p_pair_sum_r6: assert property (@(posedge le) disable iff (!rst_n)
    (13'(lvl_true) + 13'(lvl_comp)) == 13'd4095);

  p_reset_zero_r7: assert property (@(posedge le)
    !rst_n |=> (seg_unit == '0 && seg_bin == '0 && seg_lad == '0 && lvl_comp == 12'd4095));

endmodule

bind seg_dac_front seg_dac_front_chk u_chk (.*);

// File: tb/test_seg_dac_front.sv
module test_seg_dac_front;
  logic        le = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] code_in = '0;
  logic [14:0] seg_unit;
  logic [1:0]  seg_bin;
  logic [5:0]  seg_lad;
  logic [11:0] lvl_true;
  logic [11:0] lvl_comp;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 le = ~le;

  seg_dac_front i_seg_dac_front (
    .le(le), .rst_n(rst_n), .code_in(code_in),
    .seg_unit(seg_unit), .seg_bin(seg_bin), .seg_lad(seg_lad),
    .lvl_true(lvl_true), .lvl_comp(lvl_comp)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_code(input int c);
    int k, recon;
    k = c >> 8;
    check("R1 unit lines", int'(seg_unit), (1 << k) - 1);
    check("R2 binary bits", int'(seg_bin), (c >> 6) & 3);
    check("R3 ladder bits", int'(seg_lad), c & 63);
    check("R4 true level", int'(lvl_true), c);
    check("R6 complement", int'(lvl_comp), 4095 - c);
    check("R6 level sum", int'(lvl_true) + int'(lvl_comp), 4095);
    recon = 256 * $countones(seg_unit) + 128 * int'(seg_bin[1])
          + 64 * int'(seg_bin[0]) + int'(seg_lad);
    check("R8 reconstruction", recon, c);
  endtask

  task automatic check_zero(input string req);
    check(req, int'(seg_unit), 0);
    check(req, int'(seg_bin), 0);
    check(req, int'(seg_lad), 0);
    check(req, int'(lvl_true), 0);
    check(req, int'(lvl_comp), 4095);
  endtask

  initial begin
    code_in = 12'hABC;
    repeat (3) @(posedge le);
    @(negedge le);
    check_zero("R7 reset state");

    rst_n = 1'b1;
    for (int c = 0; c < 4096; c++) begin
      code_in = 12'(c);
      @(posedge le);
      #2 code_in = ~12'(c);
      @(negedge le);
      check_code(c);
      check("R5 hold after high-phase change", int'(lvl_true), c);
      if (c == 2049) begin
        code_in = 12'hFFF;
        rst_n = 1'b0;
        @(posedge le);
        #1 rst_n = 1'b1;
        @(negedge le);
        check_zero("R7 reset mid-sweep");
      end
    end

    code_in = 12'hF3A;
    @(posedge le);
    #1 code_in = 12'h000;
    #1 code_in = 12'h5A5;
    @(negedge le);
    #1 code_in = 12'h123;
    #2;
    check("R5 hold in low phase", int'(lvl_true), 12'hF3A);
    check("R4 edge capture", int'(seg_unit), 15'h7FFF);
    @(posedge le);
    @(negedge le);
    check_code(12'h123);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(8 * 30000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule